// File: doc/BRIEF.md
# Dual-Port SRAM Access Controller

This block fronts a 64 KB on-chip SRAM organised as two 32 KB banks. Address bit 15 picks the bank. A primary port carries processor references and a secondary port carries DMA-style masters. A single 32-bit configuration word, written through its own register port, controls the block. It holds a 64 KB-aligned base address, the module enable, the secondary-port enable, write protection, five address-space mask bits and one priority bit per bank.

On the primary port the block decodes each reference in the same cycle. The reference is either a hit, a miss passed on as an ordinary non-SRAM reference, or an access error for a write under write protection. The secondary port presents a 16-bit offset inside the SRAM and is either served or refused.

When both ports want the same bank in one cycle, a per-bank arbiter grants one of them and stalls the other for that cycle. The stalled port is served in the next cycle. Requests to different banks proceed together. Reads return data one cycle after the grant. The array model keeps 2^STORE_AW words per bank, and higher offset bits alias onto them.

Each bank arbiter is a state machine with three states:
- ARB_FREE: no debt. A tie goes to the bank's priority bit.
- ARB_OWE_P: the primary port lost the previous cycle and wins any tie now.
- ARB_OWE_S: the secondary port lost the previous cycle and wins any tie now.

Transitions are taken on every clock edge:
- Any state goes to ARB_OWE_P on a tie the primary port loses.
- Any state goes to ARB_OWE_S on a tie the secondary port loses.
- Any state goes to ARB_FREE in a cycle without a tie.
- Reset enters ARB_FREE.

Top module: `dpsram_ctrl`

## Requirements
- R1: After reset the configuration word reads 0, so the module is disabled: every primary request completes as a miss (p_ready=1, p_miss=1) and every secondary request is refused.
- R2: A primary request is a hit only when the enable bit (bit 0) is 1 and p_addr[31:16] equals the base field (bits 31:16). Otherwise it completes in the same cycle as a miss, with p_ready=1 and p_err=0.
- R3: Mask bits 5..9 belong to the p_space codes 0..4 (0 user data, 1 user code, 2 supervisor data, 3 supervisor code, 4 CPU space / interrupt acknowledge); codes 5..7 are never masked. A reference whose space is masked is a miss, never an error, and leaves the array unchanged.
- R4: With write protect (bit 1) set, a primary write that hits completes in the same cycle with p_err=1 and p_ready=1, and the array is not changed. Reads are still served.
- R5: A secondary request is refused in its cycle (s_ready=1, s_refused=1) when the enable bit is 0, when the secondary-enable bit (bit 2) is 0, or when it is a write while write protect is set. The array is not changed.
- R6: On a same-bank tie with no pending debt, the priority bit of that bank decides the winner: bit 3 for the lower bank (addr bit 15 = 0) and bit 4 for the upper bank. A 1 lets the secondary port win and a 0 lets the primary port win. The winner sees ready=1 and the loser ready=0.
- R7: A port stalled by a tie is served in the next cycle if it still requests the same bank, even when the other port requests it again against the priority bit.
- R8: Requests from both ports to different banks are both granted in the same cycle.
- R9: A granted read raises p_rvalid / s_rvalid with the word's data exactly one cycle after the grant. No rvalid appears otherwise.
- R10: Byte enables select which bytes a granted write changes, on both ports (be[i] covers data bits 8i+7:8i).
- R11: Configuration writes take effect at the next clock edge. Bits 15:10 are reserved and always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| p_req | input | 1 | Primary request |
| p_we | input | 1 | Primary write (1) or read (0) |
| p_addr | input | 32 | Primary byte address |
| p_space | input | 3 | Primary address-space code |
| p_be | input | DATA_W/8 | Primary byte enables |
| p_wdata | input | DATA_W | Primary write data |
| p_ready | output | 1 | Primary request completes this cycle |
| p_miss | output | 1 | Primary reference is not an SRAM hit |
| p_err | output | 1 | Primary write rejected by write protection |
| p_rvalid | output | 1 | Primary read data valid |
| p_rdata | output | DATA_W | Primary read data |
| s_req | input | 1 | Secondary request |
| s_we | input | 1 | Secondary write (1) or read (0) |
| s_addr | input | 16 | Secondary byte offset in the SRAM |
| s_be | input | DATA_W/8 | Secondary byte enables |
| s_wdata | input | DATA_W | Secondary write data |
| s_ready | output | 1 | Secondary request completes this cycle |
| s_refused | output | 1 | Secondary request refused |
| s_rvalid | output | 1 | Secondary read data valid |
| s_rdata | output | DATA_W | Secondary read data |

## Verification
Ready, miss, error and refusal are decoded combinationally, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples them 2 ns later. Read data and rvalid come from a register and are due one cycle after the grant. The bench samples them 1 ns after the rising edge that ends the granting cycle and compares them with a bench memory model updated only by writes it expects to be accepted. A configuration write is issued a full cycle before the first request that depends on it, so its effect is already visible to that request.

// File: rtl/sramctl_pkg.sv
package sramctl_pkg;

    localparam int NUM_BANKS = 2;
    localparam int BANK_BIT  = 15;

    // Configuration word, MSB first
    typedef struct packed {
        logic [15:0] base;    // 31:16 64 KB-aligned base
        logic [5:0]  rsvd;    // 15:10 always zero
        logic [4:0]  mask;    // 9:5  per-space inhibit, index = space code
        logic        pri_hi;  // 4    upper bank: 1 = secondary wins
        logic        pri_lo;  // 3    lower bank: 1 = secondary wins
        logic        sec_en;  // 2    secondary port enable
        logic        wp;      // 1    write protect
        logic        en;      // 0    module enable
    } cfg_t;

    typedef enum logic [1:0] {
        ARB_FREE  = 2'd0,
        ARB_OWE_P = 2'd1,
        ARB_OWE_S = 2'd2
    } arb_state_e;

endpackage

// File: rtl/sram_cfg_reg.sv
module sram_cfg_reg
    import sramctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output cfg_t        cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q      <= cfg_t'(wdata);
            cfg_q.rsvd <= '0;
        end
    end

endmodule

// File: rtl/sram_bank_arb.sv
module sram_bank_arb
    import sramctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic p_want,
    input  logic s_want,
    input  logic s_first,
    output logic gnt_p,
    output logic gnt_s
);

    arb_state_e state_q, state_d;
    logic       p_wins;
    logic       tie;

    assign tie = p_want && s_want;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // tie winner for the current state
    always_comb begin
        unique case (state_q)
            ARB_OWE_P: p_wins = 1'b1;
            ARB_OWE_S: p_wins = 1'b0;
            default:   p_wins = !s_first;
        endcase
    end

    // next state
    always_comb begin
        if (!tie) begin
            state_d = ARB_FREE;
        end else if (p_wins) begin
            state_d = ARB_OWE_S;
        end else begin
            state_d = ARB_OWE_P;
        end
    end

    // outputs
    always_comb begin
        gnt_p = p_want && (!s_want || p_wins);
        gnt_s = s_want && (!p_want || !p_wins);
    end

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int DATA_W   = 32,
    parameter int STORE_AW = 8
) (
    input  logic                  clk,
    input  logic                  en,
    input  logic                  we,
    input  logic [STORE_AW-1:0]   idx,
    input  logic [DATA_W/8-1:0]   be,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata
);

    localparam int DEPTH = 1 << STORE_AW;
    localparam int BE_W  = DATA_W / 8;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int i = 0; i < BE_W; i++) begin
                    if (be[i]) begin
                        mem[idx][8*i +: 8] <= wdata[8*i +: 8];
                    end
                end
            end else begin
                rdata <= mem[idx];
            end
        end
    end

endmodule

// File: rtl/dpsram_ctrl.sv
module dpsram_ctrl
    import sramctl_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int STORE_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 p_req,
    input  logic                 p_we,
    input  logic [31:0]          p_addr,
    input  logic [2:0]           p_space,
    input  logic [DATA_W/8-1:0]  p_be,
    input  logic [DATA_W-1:0]    p_wdata,
    output logic                 p_ready,
    output logic                 p_miss,
    output logic                 p_err,
    output logic                 p_rvalid,
    output logic [DATA_W-1:0]    p_rdata,
    input  logic                 s_req,
    input  logic                 s_we,
    input  logic [15:0]          s_addr,
    input  logic [DATA_W/8-1:0]  s_be,
    input  logic [DATA_W-1:0]    s_wdata,
    output logic                 s_ready,
    output logic                 s_refused,
    output logic                 s_rvalid,
    output logic [DATA_W-1:0]    s_rdata
);

    localparam int BE_W     = DATA_W / 8;
    localparam int WORD_LSB = $clog2(BE_W);

    cfg_t cfg;

    sram_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg)
    );

    assign cfg_rdata = cfg;

    // primary decode
    logic                p_masked;
    logic                p_hit;
    logic                p_need;
    logic                p_bank;
    logic [STORE_AW-1:0] p_idx;

    always_comb begin
        unique case (p_space)
            3'd0:    p_masked = cfg.mask[0];
            3'd1:    p_masked = cfg.mask[1];
            3'd2:    p_masked = cfg.mask[2];
            3'd3:    p_masked = cfg.mask[3];
            3'd4:    p_masked = cfg.mask[4];
            default: p_masked = 1'b0;
        endcase
    end

    assign p_hit  = cfg.en && (p_addr[31:BANK_BIT+1] == cfg.base) && !p_masked;
    assign p_need = p_req && p_hit && !(p_we && cfg.wp);
    assign p_bank = p_addr[BANK_BIT];
    assign p_idx  = p_addr[WORD_LSB +: STORE_AW];

    // secondary decode
    logic                s_allowed;
    logic                s_need;
    logic                s_bank;
    logic [STORE_AW-1:0] s_idx;

    assign s_allowed = cfg.en && cfg.sec_en && !(s_we && cfg.wp);
    assign s_need    = s_req && s_allowed;
    assign s_bank    = s_addr[BANK_BIT];
    assign s_idx     = s_addr[WORD_LSB +: STORE_AW];

    // per-bank arbitration and storage
    logic [NUM_BANKS-1:0] want_p, want_s, gnt_p, gnt_s, pri_v;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

    assign pri_v = {cfg.pri_hi, cfg.pri_lo};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign want_p[b] = p_need && (p_bank == 1'(b));
        assign want_s[b] = s_need && (s_bank == 1'(b));

        sram_bank_arb u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .p_want  (want_p[b]),
            .s_want  (want_s[b]),
            .s_first (pri_v[b]),
            .gnt_p   (gnt_p[b]),
            .gnt_s   (gnt_s[b])
        );

        sram_bank #(
            .DATA_W   (DATA_W),
            .STORE_AW (STORE_AW)
        ) u_mem (
            .clk   (clk),
            .en    (gnt_p[b] || gnt_s[b]),
            .we    (gnt_p[b] ? p_we    : s_we),
            .idx   (gnt_p[b] ? p_idx   : s_idx),
            .be    (gnt_p[b] ? p_be    : s_be),
            .wdata (gnt_p[b] ? p_wdata : s_wdata),
            .rdata (bank_rdata[b])
        );
    end

    // port responses
    assign p_miss    = p_req && !p_hit;
    assign p_err     = p_req && p_hit && p_we && cfg.wp;
    assign p_ready   = p_req && (!p_need || (|gnt_p));
    assign s_refused = s_req && !s_allowed;
    assign s_ready   = s_req && (!s_need || (|gnt_s));

    // read return, one cycle after grant
    logic p_rd_q, s_rd_q, p_bank_q, s_bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_rd_q   <= 1'b0;
            s_rd_q   <= 1'b0;
            p_bank_q <= 1'b0;
            s_bank_q <= 1'b0;
        end else begin
            p_rd_q   <= (|gnt_p) && !p_we;
            s_rd_q   <= (|gnt_s) && !s_we;
            p_bank_q <= p_bank;
            s_bank_q <= s_bank;
        end
    end

    assign p_rvalid = p_rd_q;
    assign s_rvalid = s_rd_q;
    assign p_rdata  = bank_rdata[p_bank_q];
    assign s_rdata  = bank_rdata[s_bank_q];

endmodule

// File: rtl/dpsram_ctrl_chk.sv
module dpsram_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rdata,
    input logic        p_req,
    input logic        p_we,
    input logic [31:0] p_addr,
    input logic        p_ready,
    input logic        p_miss,
    input logic        p_err,
    input logic        p_rvalid,
    input logic        s_req,
    input logic        s_we,
    input logic [15:0] s_addr,
    input logic        s_ready,
    input logic        s_refused,
    input logic        s_rvalid
);

    logic p_rd_ok, s_rd_ok;
    assign p_rd_ok = p_req && p_ready && !p_we && !p_miss && !p_err;
    assign s_rd_ok = s_req && s_ready && !s_we && !s_refused;

    assert_disabled_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && !cfg_rdata[0]) |-> p_miss);

    assert_miss_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_miss) |-> (p_ready && !p_err));

    assert_wp_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_we && cfg_rdata[1] && !p_miss) |-> (p_err && p_ready));

    assert_sec_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !cfg_rdata[2]) |-> (s_refused && s_ready));

    assert_p_served_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && !p_ready) |=> (!p_req || p_ready || (p_addr[15] != $past(p_addr[15]))));

    assert_s_served_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !s_ready) |=> (!s_req || s_ready || (s_addr[15] != $past(s_addr[15]))));

    assert_p_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        p_rd_ok |=> p_rvalid);

    assert_p_no_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !p_rd_ok |=> !p_rvalid);

    assert_s_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_rd_ok |=> s_rvalid);

    assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[15:10] == 6'd0);

endmodule

bind dpsram_ctrl dpsram_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .p_req     (p_req),
    .p_we      (p_we),
    .p_addr    (p_addr),
    .p_ready   (p_ready),
    .p_miss    (p_miss),
    .p_err     (p_err),
    .p_rvalid  (p_rvalid),
    .s_req     (s_req),
    .s_we      (s_we),
    .s_addr    (s_addr),
    .s_ready   (s_ready),
    .s_refused (s_refused),
    .s_rvalid  (s_rvalid)
);

// File: tb/test_dpsram_ctrl.sv
`timescale 1ns/1ps
module test_dpsram_ctrl;

    localparam logic [15:0] BASE = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        p_req = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0;
    logic [2:0]  p_space = '0;
    logic [3:0]  p_be = '0;
    logic [31:0] p_wdata = '0;
    logic        p_ready, p_miss, p_err, p_rvalid;
    logic [31:0] p_rdata;
    logic        s_req = 1'b0, s_we = 1'b0;
    logic [15:0] s_addr = '0;
    logic [3:0]  s_be = '0;
    logic [31:0] s_wdata = '0;
    logic        s_ready, s_refused, s_rvalid;
    logic [31:0] s_rdata;

    always #10 clk = ~clk;

    dpsram_ctrl i_dpsram_ctrl (.*);

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl [2][256];
    logic g_pr, g_pm, g_pe, g_sr, g_sf;
    logic [31:0] g_prd, g_srd;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(bit en, bit wp, bit sec, bit plo, bit phi, logic [4:0] msk);
        return {BASE, 6'd0, msk, phi, plo, sec, wp, en};
    endfunction

    function automatic logic [15:0] off(bit bank, logic [7:0] w);
        return {bank, 5'd0, w, 2'b00};
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    task automatic setcfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step(input bit pr, input bit pwe, input logic [31:0] pa, input logic [2:0] psp,
                        input logic [3:0] pbe, input logic [31:0] pwd,
                        input bit sr, input bit swe, input logic [15:0] sa,
                        input logic [3:0] sbe, input logic [31:0] swd);
        logic [31:0] ep, es;
        @(negedge clk);
        p_req = pr; p_we = pwe; p_addr = pa; p_space = psp; p_be = pbe; p_wdata = pwd;
        s_req = sr; s_we = swe; s_addr = sa; s_be = sbe; s_wdata = swd;
        ep = mdl[pa[15]][pa[9:2]];
        es = mdl[sa[15]][sa[9:2]];
        #2;
        g_pr = p_ready; g_pm = p_miss; g_pe = p_err; g_sr = s_ready; g_sf = s_refused;
        @(posedge clk);
        #1;
        g_prd = p_rdata; g_srd = s_rdata;
        if (pr && g_pr && !g_pm && !g_pe) begin
            if (pwe) mdl[pa[15]][pa[9:2]] = merge(ep, pwd, pbe);
            else chk(p_rvalid && (p_rdata == ep), "R9 primary read data", p_rdata, ep);
        end else begin
            chk(!p_rvalid, "R9 primary rvalid without grant", 32'(p_rvalid), 0);
        end
        if (sr && g_sr && !g_sf) begin
            if (swe) mdl[sa[15]][sa[9:2]] = merge(es, swd, sbe);
            else chk(s_rvalid && (s_rdata == es), "R9 secondary read data", s_rdata, es);
        end else begin
            chk(!s_rvalid, "R9 secondary rvalid without grant", 32'(s_rvalid), 0);
        end
    endtask

    task automatic idle();
        step(0, 0, '0, 0, 0, 0, 0, 0, '0, 0, 0);
    endtask

    task automatic pread(input bit bank, input logic [7:0] w, input logic [2:0] sp);
        step(1, 0, {BASE, off(bank, w)}, sp, 4'hF, 0, 0, 0, '0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        for (int b = 0; b < 2; b++) for (int w = 0; w < 256; w++) mdl[b][w] = '0;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(cfg_rdata == 32'd0, "R1 config after reset", cfg_rdata, 0);
        step(1, 0, {BASE, off(0, 8'd1)}, 0, 4'hF, 0, 1, 0, off(0, 8'd2), 4'hF, 0);
        chk(g_pr && g_pm && !g_pe, "R1 disabled primary misses", {g_pr, g_pm, g_pe}, 3'b110);
        chk(g_sr && g_sf, "R1 disabled secondary refused", {g_sr, g_sf}, 2'b11);

        // R11: reserved bits read zero, write visible next edge
        setcfg(mkcfg(1, 0, 1, 0, 0, 5'd0) | 32'h0000_FC00);
        chk(cfg_rdata == mkcfg(1, 0, 1, 0, 0, 5'd0), "R11 reserved bits cleared", cfg_rdata,
            mkcfg(1, 0, 1, 0, 0, 5'd0));

        // fill the array model through the primary port
        for (int b = 0; b < 2; b++) begin
            for (int w = 0; w < 256; w++) begin
                step(1, 1, {BASE, off(b[0], 8'(w))}, 2, 4'hF, $urandom, 0, 0, '0, 0, 0);
            end
        end

        // R2: base mismatch misses
        step(1, 0, {BASE ^ 16'h0100, off(0, 8'd5)}, 0, 4'hF, 0, 0, 0, '0, 0, 0);
        chk(g_pr && g_pm && !g_pe, "R2 base mismatch is miss", {g_pr, g_pm, g_pe}, 3'b110);
        pread(1, 8'd5, 0);
        chk(g_pr && !g_pm, "R2 base match hits", {g_pr, g_pm}, 2'b10);

        // R10: byte enables on both ports
        step(1, 1, {BASE, off(0, 8'd9)}, 0, 4'b0101, 32'h1122_3344, 0, 0, '0, 0, 0);
        pread(0, 8'd9, 0);
        chk(g_prd[23:16] == 8'h22 && g_prd[7:0] == 8'h44 && g_prd == mdl[0][9],
            "R10 primary byte enables", g_prd, mdl[0][9]);
        step(0, 0, '0, 0, 0, 0, 1, 1, off(1, 8'd9), 4'b1000, 32'hAB00_0000);
        step(0, 0, '0, 0, 0, 0, 1, 0, off(1, 8'd9), 4'hF, 0);
        chk(g_srd[31:24] == 8'hAB && g_srd == mdl[1][9], "R10 secondary byte enables", g_srd, mdl[1][9]);

        // R3: supervisor data masked (bit 7)
        setcfg(mkcfg(1, 0, 1, 0, 0, 5'b00100));
        pread(0, 8'd12, 2);
        chk(g_pr && g_pm && !g_pe, "R3 masked supervisor data is miss", {g_pr, g_pm, g_pe}, 3'b110);
        step(1, 1, {BASE, off(0, 8'd12)}, 2, 4'hF, 32'hDEAD_BEEF, 0, 0, '0, 0, 0);
        chk(g_pm && !g_pe, "R3 masked write is miss", {g_pm, g_pe}, 2'b10);
        pread(0, 8'd12, 0);
        chk(!g_pm && g_prd == mdl[0][12], "R3 masked write left array", g_prd, mdl[0][12]);
        pread(0, 8'd12, 5);
        chk(!g_pm, "R3 space code 5 never masked", 32'(g_pm), 0);

        // R4/R5: write protect
        setcfg(mkcfg(1, 1, 1, 0, 0, 5'd0));
        step(1, 1, {BASE, off(1, 8'd20)}, 0, 4'hF, 32'h0BAD_F00D, 0, 0, '0, 0, 0);
        chk(g_pr && g_pe && !g_pm, "R4 protected write errors", {g_pr, g_pe, g_pm}, 3'b110);
        pread(1, 8'd20, 0);
        chk(g_prd == mdl[1][20] && g_prd != 32'h0BAD_F00D, "R4 array unchanged", g_prd, mdl[1][20]);
        step(0, 0, '0, 0, 0, 0, 1, 1, off(0, 8'd21), 4'hF, 32'h5555_AAAA);
        chk(g_sr && g_sf, "R5 secondary write under protect refused", {g_sr, g_sf}, 2'b11);
        step(0, 0, '0, 0, 0, 0, 1, 0, off(0, 8'd21), 4'hF, 0);
        chk(g_sr && !g_sf && g_srd == mdl[0][21], "R5 secondary read under protect", g_srd, mdl[0][21]);
        setcfg(mkcfg(1, 0, 0, 0, 0, 5'd0));
        step(0, 0, '0, 0, 0, 0, 1, 0, off(0, 8'd21), 4'hF, 0);
        chk(g_sr && g_sf, "R5 secondary disabled refused", {g_sr, g_sf}, 2'b11);

        // R6/R7: lower bank, primary priority
        setcfg(mkcfg(1, 0, 1, 0, 0, 5'd0));
        step(1, 0, {BASE, off(0, 8'd30)}, 0, 4'hF, 0, 1, 0, off(0, 8'd31), 4'hF, 0);
        chk(g_pr && !g_sr, "R6 pri 0 primary wins", {g_pr, g_sr}, 2'b10);
        step(1, 0, {BASE, off(0, 8'd30)}, 0, 4'hF, 0, 1, 0, off(0, 8'd31), 4'hF, 0);
        chk(!g_pr && g_sr, "R7 stalled secondary served next", {g_pr, g_sr}, 2'b01);
        pread(0, 8'd30, 0);
        chk(g_pr, "R7 stalled primary served next", 32'(g_pr), 1);

        // R6/R7: lower bank, secondary priority
        setcfg(mkcfg(1, 0, 1, 1, 0, 5'd0));
        step(1, 0, {BASE, off(0, 8'd32)}, 0, 4'hF, 0, 1, 0, off(0, 8'd33), 4'hF, 0);
        chk(!g_pr && g_sr, "R6 pri 1 secondary wins", {g_pr, g_sr}, 2'b01);
        step(1, 0, {BASE, off(0, 8'd32)}, 0, 4'hF, 0, 1, 0, off(0, 8'd33), 4'hF, 0);
        chk(g_pr && !g_sr, "R7 stalled primary served next", {g_pr, g_sr}, 2'b10);
        idle();
        idle();

        // R6: upper bank uses its own bit
        setcfg(mkcfg(1, 0, 1, 0, 1, 5'd0));
        step(1, 0, {BASE, off(1, 8'd40)}, 0, 4'hF, 0, 1, 0, off(1, 8'd41), 4'hF, 0);
        chk(!g_pr && g_sr, "R6 upper bank secondary wins", {g_pr, g_sr}, 2'b01);
        pread(1, 8'd40, 0);

        // R8: different banks in parallel
        step(1, 0, {BASE, off(1, 8'd42)}, 0, 4'hF, 0, 1, 1, off(0, 8'd43), 4'h3, 32'h0000_7E7E);
        chk(g_pr && g_sr, "R8 different banks both served", {g_pr, g_sr}, 2'b11);
        idle();

        // constrained random phase
        for (int it = 0; it < 600; it++) begin
            int unsigned kind = $urandom % 4;
            bit          pb   = 1'($urandom);
            bit          sb   = (kind == 3) ? pb : (kind == 2) ? !pb : 1'($urandom);
            bit          pwe  = 1'($urandom);
            bit          swe  = 1'($urandom);
            logic [7:0]  pw   = 8'($urandom);
            logic [7:0]  sw   = 8'($urandom);
            bit          plo  = 1'($urandom);
            bit          phi  = 1'($urandom);
            bit          sw_p;
            if (it % 64 == 0) setcfg(mkcfg(1, 0, 1, plo, phi, 5'd0));
            sw_p = (sb == 1'b0) ? cfg_rdata[3] : cfg_rdata[4];
            step(kind != 1, pwe, {BASE, off(pb, pw)}, 3'($urandom % 5), 4'($urandom), $urandom,
                 kind != 0, swe, off(sb, sw), 4'($urandom), $urandom);
            if (kind < 3) begin
                chk((kind == 1 || g_pr) && (kind == 0 || g_sr), "R8 uncontended served",
                    {g_pr, g_sr}, 2'b11);
            end else begin
                chk(g_pr == !sw_p && g_sr == sw_p, "R6 random tie winner", {g_pr, g_sr}, {!sw_p, sw_p});
                if (sw_p) step(1, pwe, {BASE, off(pb, pw)}, 0, 4'hF, $urandom, 0, 0, '0, 0, 0);
                else      step(0, 0, '0, 0, 0, 0, 1, swe, off(sb, sw), 4'hF, $urandom);
                chk(sw_p ? g_pr : g_sr, "R7 random loser retried", 32'(sw_p ? g_pr : g_sr), 1);
            end
        end

        idle();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule